// File: doc/BRIEF.md
# Serial Port Register Bank and Interrupt Logic

This block is the host-visible side of a byte-wide asynchronous serial port. A host bus with eight byte offsets reaches a divisor latch, an interrupt-enable register, line-control, modem-control and scratch registers. It also reaches three derived views: line status, modem status and interrupt identification. The bit-serial receive and transmit engines sit outside. The receiver delivers each finished character on a strobe, together with its error flags. The transmitter pulls bytes from a one-byte holding register through a valid/ready handshake and reports when its shift register has run empty.

The divisor-access bit (line control bit 7) remaps offsets 0 and 1 onto the 16-bit divisor, which is only presented as an output. Four interrupt causes are ranked by fixed priority into one identification code and one interrupt pin. Each cause is cleared by its own bus access. A loopback mode, set by modem control bit 4, parks the serial output high. It sends transmitted bits back to the receiver input and feeds the four modem control bits into the modem status inputs.

The transmit handshake follows the usual rules: `tx_data` is stable while `tx_valid` is high, and a byte moves on a cycle where both `tx_valid` and `tx_ready` are high. The receive side has no back-pressure, because a serial line cannot be stalled. A character arriving while the previous one is unread overwrites it and raises overrun.

Top module: `uart_regbank`

## Requirements
- R1: With line control bit 7 set, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8, and `divisor` shows both. With the bit clear, offset 0 is the receive buffer (read) / holding register (write) and offset 1 is the interrupt-enable register.
- R2: The interrupt-enable register keeps bits 3:0 (0 receive data, 1 holding empty, 2 line status, 3 modem change). Bits 7:4 read as zero.
- R3: Offset 2 reads 0x01 when nothing enabled is pending. Otherwise it reads the highest-ranked enabled cause: 0x06 line status, then 0x04 data ready, then 0x02 holding empty, then 0x00 modem change.
- R4: `irq` is high exactly when at least one enabled cause is pending.
- R5: A receive strobe loads the buffer and sets line status bit 0. If `rx_brk` is set, the buffer is loaded with 0x00 and status bit 4 is set. Reading the buffer clears bit 0 unless a new byte arrives in the same cycle.
- R6: A byte that arrives while bit 0 is set and the buffer is not being read in that cycle sets bit 1 (overrun). The newest byte is kept.
- R7: Line status bits 1 (overrun), 2 (parity), 3 (framing) and 4 (break) clear on a read of offset 5. A flag set in the same cycle survives.
- R8: A write to the holding register drives `tx_valid` high with the byte on `tx_data`. A handshake returns line status bit 5 to 1. Bit 6 is bit 5 AND `tx_shift_empty`.
- R9: The holding-empty cause is raised by a handshake, or by enabling interrupt-enable bit 1 while the holding register is empty. It is dropped by a holding-register write, which wins over a handshake in the same cycle, or by a read of offset 2 that reports it.
- R10: Modem status bits 7:4 show carrier, ring, data-set-ready and clear-to-send. Bits 3:0 flag a change of each since the last sample, except that bit 2 flags only a 1-to-0 ring transition. The change flags clear on a read of offset 6.
- R11: With modem control bit 4 set: `sout` is 1, `rx_ser_o` follows `ser_tx_i`, the four modem outputs are 0, and modem status bits 4..7 follow modem control bits 1, 0, 2 and 3 (RTS, DTR, OUT1, OUT2) instead of the pins.
- R12: Line control, modem control (bits 4:0) and scratch read back as written. Line control bits 6:0 drive `break_o`, `par_stick`, `par_even`, `par_en`, `stop_long` and `word_len` (bits 1:0, 0 = 5 bits up to 3 = 8 bits), and modem control bits 3:0 drive `out2_o`, `out1_o`, `rts_o`, `dtr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe (read side effects happen on it) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error with the character |
| rx_ferr | input | 1 | Framing error with the character |
| rx_brk | input | 1 | Break detected |
| tx_valid | output | 1 | Holding register full |
| tx_data | output | 8 | Holding register byte |
| tx_ready | input | 1 | Transmit engine takes the byte |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| ser_tx_i | input | 1 | Serial bit from the transmit engine |
| ser_rx_i | input | 1 | Serial line input pin |
| sout | output | 1 | Serial line output pin |
| rx_ser_o | output | 1 | Serial bit to the receive engine |
| cts_i | input | 1 | Clear to send, active high |
| dsr_i | input | 1 | Data set ready, active high |
| ri_i | input | 1 | Ring indicator, active high |
| dcd_i | input | 1 | Carrier detect, active high |
| dtr_o | output | 1 | Data terminal ready |
| rts_o | output | 1 | Request to send |
| out1_o | output | 1 | User output 1 |
| out2_o | output | 1 | User output 2 |
| divisor | output | 16 | Baud divisor |
| word_len | output | 2 | Character length code |
| stop_long | output | 1 | Long stop period selected |
| par_en | output | 1 | Parity enabled |
| par_even | output | 1 | Even parity |
| par_stick | output | 1 | Stuck parity |
| break_o | output | 1 | Force break |

## Verification
Two pairs of functions can fall in the same cycle. A buffer read can meet a fresh receive strobe, and a holding-register write can meet a handshake from the transmit engine. The bench drives both pairs onto one clock edge on purpose. It judges the outcome by what it reads afterwards: data ready stays set with no overrun and the newer byte is in the buffer, and the holding register stays full with the holding-empty cause not raised. A behavioural model in the bench is compared with every output on every clock, so a wrong resolution shows up in the cycle it happens.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int LINES  = 4;

  localparam logic [ADDR_W-1:0] OFF_BUF   = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_IEN   = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_IID   = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_LCTL  = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_MCTL  = 3'd4;
  localparam logic [ADDR_W-1:0] OFF_LSTAT = 3'd5;
  localparam logic [ADDR_W-1:0] OFF_MSTAT = 3'd6;
  localparam logic [ADDR_W-1:0] OFF_SCR   = 3'd7;

  typedef enum logic [1:0] {
    CAUSE_MODEM = 2'b00,
    CAUSE_TXE   = 2'b01,
    CAUSE_RXD   = 2'b10,
    CAUSE_LINE  = 2'b11
  } cause_e;

  localparam int RI_POS = 2;
endpackage

// File: rtl/rb_rx_status.sv
module rb_rx_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  input  logic         rx_perr,
  input  logic         rx_ferr,
  input  logic         rx_brk,
  input  logic         buf_rd,
  input  logic         lsr_rd,
  output logic [W-1:0] rbr,
  output logic         dr,
  output logic         oe,
  output logic         pe,
  output logic         fe,
  output logic         bi
);
  logic overrun_hit;
  assign overrun_hit = rx_valid && dr && !buf_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr <= '0;
      dr  <= 1'b0;
      oe  <= 1'b0;
      pe  <= 1'b0;
      fe  <= 1'b0;
      bi  <= 1'b0;
    end else begin
      if (rx_valid) rbr <= rx_brk ? '0 : rx_data;

      if (rx_valid)    dr <= 1'b1;
      else if (buf_rd) dr <= 1'b0;

      if (overrun_hit) oe <= 1'b1;
      else if (lsr_rd) oe <= 1'b0;

      if (rx_valid && rx_perr) pe <= 1'b1;
      else if (lsr_rd)         pe <= 1'b0;

      if (rx_valid && rx_ferr) fe <= 1'b1;
      else if (lsr_rd)         fe <= 1'b0;

      if (rx_valid && rx_brk)  bi <= 1'b1;
      else if (lsr_rd)         bi <= 1'b0;
    end
  end

  p_dr_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd && !rx_valid |=> !dr);
  p_dr_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> dr);
  p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && dr && !buf_rd |=> oe);
  p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd && !rx_valid |=> !(oe || pe || fe || bi));
endmodule

// File: rtl/rb_tx_hold.sv
module rb_tx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         thr_wr,
  input  logic [W-1:0] wdata,
  input  logic         tx_ready,
  input  logic         tx_shift_empty,
  input  logic         arm,
  input  logic         iir_rd_txe,
  output logic         tx_valid,
  output logic [W-1:0] tx_data,
  output logic         thre,
  output logic         temt,
  output logic         txe_pend
);
  logic handoff;
  assign handoff  = tx_valid && tx_ready;
  assign tx_valid = !thre;
  assign temt     = thre && tx_shift_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data  <= '0;
      thre     <= 1'b1;
      txe_pend <= 1'b0;
    end else begin
      if (thr_wr) tx_data <= wdata;

      if (thr_wr)       thre <= 1'b0;
      else if (handoff) thre <= 1'b1;

      if (thr_wr)                              txe_pend <= 1'b0;
      else if (handoff || (arm && thre))       txe_pend <= 1'b1;
      else if (iir_rd_txe)                     txe_pend <= 1'b0;
    end
  end

  p_thr_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> tx_valid && !temt);
  p_handoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && !thr_wr |=> !tx_valid);
  p_txe_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !txe_pend);
  p_txe_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && !thr_wr |=> txe_pend);
endmodule

// File: rtl/rb_modem_status.sv
module rb_modem_status #(
  parameter int N      = 4,
  parameter int RI_IDX = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ext_lines,
  input  logic [N-1:0] loop_lines,
  input  logic         loopback,
  input  logic         msr_rd,
  output logic [N-1:0] level,
  output logic [N-1:0] delta
);
  logic [N-1:0] prev_q;
  logic [N-1:0] chg;
  logic         primed_q;

  assign level = loopback ? loop_lines : ext_lines;

  for (genvar g = 0; g < N; g++) begin : g_line
    if (g == RI_IDX) begin : g_trail
      assign chg[g] = prev_q[g] & ~level[g];
    end else begin : g_any
      assign chg[g] = prev_q[g] ^ level[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      delta    <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= level;
      primed_q <= 1'b1;
      for (int i = 0; i < N; i++) begin
        if (primed_q && chg[i]) delta[i] <= 1'b1;
        else if (msr_rd)        delta[i] <= 1'b0;
      end
    end
  end

  p_ri_rise_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !msr_rd && !prev_q[RI_IDX] |=> $stable(delta[RI_IDX]));
  p_msr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msr_rd && (level == prev_q) |=> delta == '0);
endmodule

// File: rtl/rb_irq_encode.sv
module rb_irq_encode
  import uart_rb_pkg::*;
(
  input  logic [3:0]        en,
  input  logic              line_err,
  input  logic              rx_ready,
  input  logic              txe_pend,
  input  logic              modem_chg,
  output logic [BYTE_W-1:0] iir,
  output logic              irq,
  output logic              txe_top
);
  logic   ls_p, da_p, te_p, ms_p;
  cause_e cause;

  assign ls_p = en[2] && line_err;
  assign da_p = en[0] && rx_ready;
  assign te_p = en[1] && txe_pend;
  assign ms_p = en[3] && modem_chg;
  assign irq  = ls_p || da_p || te_p || ms_p;

  always_comb begin
    if (ls_p)      cause = CAUSE_LINE;
    else if (da_p) cause = CAUSE_RXD;
    else if (te_p) cause = CAUSE_TXE;
    else           cause = CAUSE_MODEM;
  end

  assign txe_top = irq && (cause == CAUSE_TXE);
  assign iir     = {5'b00000, cause, ~irq};
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter logic [2*BYTE_W-1:0] DIV_RESET = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [BYTE_W-1:0]   bus_wdata,
  output logic [BYTE_W-1:0]   bus_rdata,
  output logic                irq,
  input  logic                rx_valid,
  input  logic [BYTE_W-1:0]   rx_data,
  input  logic                rx_perr,
  input  logic                rx_ferr,
  input  logic                rx_brk,
  output logic                tx_valid,
  output logic [BYTE_W-1:0]   tx_data,
  input  logic                tx_ready,
  input  logic                tx_shift_empty,
  input  logic                ser_tx_i,
  input  logic                ser_rx_i,
  output logic                sout,
  output logic                rx_ser_o,
  input  logic                cts_i,
  input  logic                dsr_i,
  input  logic                ri_i,
  input  logic                dcd_i,
  output logic                dtr_o,
  output logic                rts_o,
  output logic                out1_o,
  output logic                out2_o,
  output logic [2*BYTE_W-1:0] divisor,
  output logic [1:0]          word_len,
  output logic                stop_long,
  output logic                par_en,
  output logic                par_even,
  output logic                par_stick,
  output logic                break_o
);
  localparam int DIV_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] dll_q, dlm_q, lcr_q, scr_q;
  logic [3:0]        ier_q;
  logic [4:0]        mcr_q;
  logic              dlab, loopback;

  assign dlab     = lcr_q[7];
  assign loopback = mcr_q[4];

  logic sel_buf, sel_ien;
  assign sel_buf = (bus_addr == OFF_BUF);
  assign sel_ien = (bus_addr == OFF_IEN);

  logic wr_dll, wr_dlm, wr_thr, wr_ier;
  assign wr_dll = bus_wr && sel_buf && dlab;
  assign wr_dlm = bus_wr && sel_ien && dlab;
  assign wr_thr = bus_wr && sel_buf && !dlab;
  assign wr_ier = bus_wr && sel_ien && !dlab;

  logic rd_buf, rd_lsr, rd_msr, rd_iir;
  assign rd_buf = bus_rd && sel_buf && !dlab;
  assign rd_lsr = bus_rd && (bus_addr == OFF_LSTAT);
  assign rd_msr = bus_rd && (bus_addr == OFF_MSTAT);
  assign rd_iir = bus_rd && (bus_addr == OFF_IID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dll_q <= DIV_RESET[BYTE_W-1:0];
      dlm_q <= DIV_RESET[DIV_W-1:BYTE_W];
      lcr_q <= '0;
      scr_q <= '0;
      ier_q <= '0;
      mcr_q <= '0;
    end else if (bus_wr) begin
      if (wr_dll) dll_q <= bus_wdata;
      if (wr_dlm) dlm_q <= bus_wdata;
      if (wr_ier) ier_q <= bus_wdata[3:0];
      if (bus_addr == OFF_LCTL) lcr_q <= bus_wdata;
      if (bus_addr == OFF_MCTL) mcr_q <= bus_wdata[4:0];
      if (bus_addr == OFF_SCR)  scr_q <= bus_wdata;
    end
  end

  // receive side
  logic [BYTE_W-1:0] rbr;
  logic dr, oe, pe, fe, bi;
  rb_rx_status #(.W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .buf_rd(rd_buf), .lsr_rd(rd_lsr),
    .rbr(rbr), .dr(dr), .oe(oe), .pe(pe), .fe(fe), .bi(bi)
  );

  // transmit side
  logic thre, temt, txe_pend, txe_top, arm;
  assign arm = wr_ier && bus_wdata[1] && !ier_q[1];
  rb_tx_hold #(.W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .thr_wr(wr_thr), .wdata(bus_wdata),
    .tx_ready(tx_ready), .tx_shift_empty(tx_shift_empty), .arm(arm),
    .iir_rd_txe(rd_iir && txe_top),
    .tx_valid(tx_valid), .tx_data(tx_data), .thre(thre), .temt(temt),
    .txe_pend(txe_pend)
  );

  // modem side: index 0 cts, 1 dsr, 2 ri, 3 dcd
  logic [LINES-1:0] m_level, m_delta, ext_lines, loop_lines;
  assign ext_lines  = {dcd_i, ri_i, dsr_i, cts_i};
  assign loop_lines = {mcr_q[3], mcr_q[2], mcr_q[0], mcr_q[1]};
  rb_modem_status #(.N(LINES), .RI_IDX(RI_POS)) u_modem (
    .clk(clk), .rst_n(rst_n), .ext_lines(ext_lines), .loop_lines(loop_lines),
    .loopback(loopback), .msr_rd(rd_msr), .level(m_level), .delta(m_delta)
  );

  logic [BYTE_W-1:0] iir_val;
  logic              line_err;
  assign line_err = oe || pe || fe || bi;
  rb_irq_encode u_irq (
    .en(ier_q), .line_err(line_err), .rx_ready(dr), .txe_pend(txe_pend),
    .modem_chg(|m_delta), .iir(iir_val), .irq(irq), .txe_top(txe_top)
  );

  logic [BYTE_W-1:0] lsr_val, msr_val;
  assign lsr_val = {1'b0, temt, thre, bi, fe, pe, oe, dr};
  assign msr_val = {m_level, m_delta};

  always_comb begin
    case (bus_addr)
      OFF_BUF:   bus_rdata = dlab ? dll_q : rbr;
      OFF_IEN:   bus_rdata = dlab ? dlm_q : {4'b0000, ier_q};
      OFF_IID:   bus_rdata = iir_val;
      OFF_LCTL:  bus_rdata = lcr_q;
      OFF_MCTL:  bus_rdata = {3'b000, mcr_q};
      OFF_LSTAT: bus_rdata = lsr_val;
      OFF_MSTAT: bus_rdata = msr_val;
      default:   bus_rdata = scr_q;
    endcase
  end

  assign sout      = loopback ? 1'b1 : ser_tx_i;
  assign rx_ser_o  = loopback ? ser_tx_i : ser_rx_i;
  assign dtr_o     = mcr_q[0] && !loopback;
  assign rts_o     = mcr_q[1] && !loopback;
  assign out1_o    = mcr_q[2] && !loopback;
  assign out2_o    = mcr_q[3] && !loopback;
  assign divisor   = {dlm_q, dll_q};
  assign word_len  = lcr_q[1:0];
  assign stop_long = lcr_q[2];
  assign par_en    = lcr_q[3];
  assign par_even  = lcr_q[4];
  assign par_stick = lcr_q[5];
  assign break_o   = lcr_q[6];

  p_loop_sout_r11: assert property (@(posedge clk) disable iff (!rst_n)
    loopback |-> sout && !(dtr_o || rts_o || out1_o || out2_o));
  p_line_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ier_q[2] && (oe || pe || fe || bi) |-> iir_val == 8'h06);
  p_quiet_iir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> iir_val == 8'h01);
  p_div_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dll |=> divisor[BYTE_W-1:0] == $past(bus_wdata));
endmodule

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [2:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic irq;
  logic rx_valid = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0;
  logic [7:0] rx_data = '0;
  logic tx_valid, tx_ready = 0, tx_shift_empty = 1;
  logic [7:0] tx_data;
  logic ser_tx_i = 1, ser_rx_i = 1, sout, rx_ser_o;
  logic cts_i = 0, dsr_i = 0, ri_i = 0, dcd_i = 0;
  logic dtr_o, rts_o, out1_o, out2_o;
  logic [15:0] divisor;
  logic [1:0] word_len;
  logic stop_long, par_en, par_even, par_stick, break_o;

  uart_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .rx_brk(rx_brk), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .tx_shift_empty(tx_shift_empty), .ser_tx_i(ser_tx_i), .ser_rx_i(ser_rx_i),
    .sout(sout), .rx_ser_o(rx_ser_o), .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i),
    .dcd_i(dcd_i), .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o), .out2_o(out2_o),
    .divisor(divisor), .word_len(word_len), .stop_long(stop_long), .par_en(par_en),
    .par_even(par_even), .par_stick(par_stick), .break_o(break_o)
  );

  int checks = 0, fails = 0;
  logic [7:0] samp_rdata;
  byte unsigned rx_hist[$];

  // behavioural reference state
  logic [7:0] m_dll = 0, m_dlm = 0, m_lcr = 0, m_scr = 0, m_rbr = 0, m_thr = 0;
  logic [3:0] m_ier = 0, m_prev = 0, m_delta = 0;
  logic [4:0] m_mcr = 0;
  bit m_dr = 0, m_oe = 0, m_pe = 0, m_fe = 0, m_bi = 0, m_thre = 1, m_ip = 0, m_primed = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] m_src();
    if (m_mcr[4]) return {m_mcr[3], m_mcr[2], m_mcr[0], m_mcr[1]};
    return {dcd_i, ri_i, dsr_i, cts_i};
  endfunction

  function automatic logic [7:0] m_iir();
    if (m_ier[2] && (m_oe || m_pe || m_fe || m_bi)) return 8'h06;
    if (m_ier[0] && m_dr) return 8'h04;
    if (m_ier[1] && m_ip) return 8'h02;
    if (m_ier[3] && (m_delta != 0)) return 8'h00;
    return 8'h01;
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_lcr[7] ? m_dll : m_rbr;
      3'd1: return m_lcr[7] ? m_dlm : {4'h0, m_ier};
      3'd2: return m_iir();
      3'd3: return m_lcr;
      3'd4: return {3'b000, m_mcr};
      3'd5: return {1'b0, m_thre && tx_shift_empty, m_thre, m_bi, m_fe, m_pe, m_oe, m_dr};
      3'd6: return {m_src(), m_delta};
      default: return m_scr;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R1";
      3'd2: return "R3";
      3'd5: return "R7";
      3'd6: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic model_step();
    bit dlab, rd_buf, wr_thr, rd_lsr, rd_msr, rd_iir, handoff, arm, txe_top;
    logic [3:0] src;
    dlab    = m_lcr[7];
    rd_buf  = bus_rd && bus_addr == 0 && !dlab;
    wr_thr  = bus_wr && bus_addr == 0 && !dlab;
    rd_lsr  = bus_rd && bus_addr == 5;
    rd_msr  = bus_rd && bus_addr == 6;
    rd_iir  = bus_rd && bus_addr == 2;
    handoff = !m_thre && tx_ready;
    arm     = bus_wr && bus_addr == 1 && !dlab && bus_wdata[1] && !m_ier[1];
    txe_top = (m_iir() == 8'h02);
    src     = m_src();
    // receive
    if (rx_valid && m_dr && !rd_buf) m_oe = 1; else if (rd_lsr) m_oe = 0;
    if (rx_valid && rx_perr) m_pe = 1; else if (rd_lsr) m_pe = 0;
    if (rx_valid && rx_ferr) m_fe = 1; else if (rd_lsr) m_fe = 0;
    if (rx_valid && rx_brk) m_bi = 1; else if (rd_lsr) m_bi = 0;
    if (rx_valid) begin
      m_rbr = rx_brk ? 8'h00 : rx_data;
      m_dr = 1;
    end else if (rd_buf) m_dr = 0;
    // transmit
    if (wr_thr) m_ip = 0;
    else if (handoff || (arm && m_thre)) m_ip = 1;
    else if (rd_iir && txe_top) m_ip = 0;
    if (wr_thr) begin m_thre = 0; m_thr = bus_wdata; end
    else if (handoff) m_thre = 1;
    // modem
    for (int i = 0; i < 4; i++) begin
      bit c;
      c = (i == 2) ? (m_prev[i] && !src[i]) : (m_prev[i] != src[i]);
      if (m_primed && c) m_delta[i] = 1; else if (rd_msr) m_delta[i] = 0;
    end
    m_prev = src;
    m_primed = 1;
    // registers
    if (bus_wr) begin
      if (bus_addr == 0 && dlab) m_dll = bus_wdata;
      if (bus_addr == 1 && dlab) m_dlm = bus_wdata;
      if (bus_addr == 1 && !dlab) m_ier = bus_wdata[3:0];
      if (bus_addr == 3) m_lcr = bus_wdata;
      if (bus_addr == 4) m_mcr = bus_wdata[4:0];
      if (bus_addr == 7) m_scr = bus_wdata;
    end
  endtask

  task automatic tick();
    bit lb;
    #4;
    lb = m_mcr[4];
    chk(tag_of(bus_addr), {8'h00, bus_rdata}, {8'h00, m_read(bus_addr)});
    chk("R4", {15'd0, irq}, {15'd0, m_iir() != 8'h01});
    chk("R8", {7'd0, tx_valid, tx_data}, {7'd0, !m_thre, m_thr});
    chk("R11", {10'd0, sout, rx_ser_o, dtr_o, rts_o, out1_o, out2_o},
        {10'd0, lb ? 1'b1 : ser_tx_i, lb ? ser_tx_i : ser_rx_i,
         m_mcr[0] && !lb, m_mcr[1] && !lb, m_mcr[2] && !lb, m_mcr[3] && !lb});
    chk("R1", divisor, {m_dlm, m_dll});
    chk("R12", {9'd0, break_o, par_stick, par_even, par_en, stop_long, word_len},
        {9'd0, m_lcr[6:0]});
    samp_rdata = bus_rdata;
    if (rx_valid) rx_hist.push_back(rx_data);
    model_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    bus_rd = 1; bus_addr = a;
    tick();
    bus_rd = 0;
    chk(tag, {8'h00, samp_rdata}, {8'h00, exp});
  endtask

  task automatic rx_put(input logic [7:0] d, input bit p, input bit f, input bit b);
    rx_valid = 1; rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b;
    tick();
    rx_valid = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd(3'd2, 8'h01, "R3");
    rd(3'd5, 8'h60, "R8");
    rd(3'd6, 8'h00, "R10");
    rd(3'd3, 8'h00, "R12");
    // divisor remap
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h0C);
    wr(3'd1, 8'h01);
    rd(3'd0, 8'h0C, "R1");
    rd(3'd1, 8'h01, "R1");
    chk("R1", divisor, 16'h010C);
    wr(3'd3, 8'h1B);
    chk("R12", {14'd0, word_len}, 16'd3);
    chk("R12", {14'd0, par_en, par_even}, 16'd3);
    rd(3'd1, 8'h00, "R1");
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'h0F, "R2");
    rd(3'd2, 8'h02, "R9");
    rd(3'd2, 8'h01, "R9");
    chk("R4", {15'd0, irq}, 16'd0);
    wr(3'd7, 8'h5A);
    rd(3'd7, 8'h5A, "R12");
    wr(3'd4, 8'h0F);
    chk("R12", {12'd0, dtr_o, rts_o, out1_o, out2_o}, 16'h000F);
    rd(3'd4, 8'h0F, "R12");
    wr(3'd4, 8'h00);
    // receive
    rx_put(8'hA5, 0, 0, 0);
    rd(3'd5, 8'h61, "R5");
    rd(3'd2, 8'h04, "R3");
    rd(3'd0, 8'hA5, "R5");
    rd(3'd5, 8'h60, "R5");
    rx_put(8'h11, 0, 0, 0);
    rx_put(8'h22, 0, 0, 0);
    rd(3'd2, 8'h06, "R3");
    rd(3'd5, 8'h63, "R6");
    rd(3'd2, 8'h04, "R3");
    rd(3'd5, 8'h61, "R7");
    rd(3'd0, 8'h22, "R6");
    rx_put(8'h7E, 0, 1, 1);
    rd(3'd5, 8'h79, "R5");
    rd(3'd0, 8'h00, "R5");
    rd(3'd5, 8'h60, "R7");
    // read meets arrival in one cycle
    rx_put(8'h44, 0, 0, 0);
    rx_valid = 1; rx_data = 8'h45; bus_rd = 1; bus_addr = 3'd0;
    tick();
    rx_valid = 0; bus_rd = 0;
    chk("R5", {8'h00, samp_rdata}, 16'h0044);
    rd(3'd5, 8'h61, "R6");
    rd(3'd0, 8'h45, "R5");
    chk("R5", 16'(rx_hist.size()), 16'd6);
    // transmit
    tx_shift_empty = 0;
    wr(3'd0, 8'h3C);
    chk("R8", {7'd0, tx_valid, tx_data}, 16'h013C);
    rd(3'd5, 8'h00, "R8");
    tx_ready = 1; tick(); tx_ready = 0;
    rd(3'd5, 8'h20, "R8");
    rd(3'd2, 8'h02, "R9");
    tx_shift_empty = 1;
    rd(3'd5, 8'h60, "R8");
    // write meets handoff in one cycle
    wr(3'd0, 8'h01);
    tx_ready = 1; bus_wr = 1; bus_addr = 3'd0; bus_wdata = 8'h02;
    tick();
    tx_ready = 0; bus_wr = 0;
    chk("R8", {7'd0, tx_valid, tx_data}, 16'h0102);
    rd(3'd2, 8'h01, "R9");
    tx_ready = 1; tick(); tx_ready = 0;
    rd(3'd2, 8'h02, "R9");
    rd(3'd2, 8'h01, "R9");
    // modem status
    wr(3'd1, 8'h08);
    cts_i = 1; tick();
    rd(3'd6, 8'h11, "R10");
    rd(3'd6, 8'h10, "R10");
    ri_i = 1; tick();
    rd(3'd6, 8'h50, "R10");
    ri_i = 0; tick();
    rd(3'd2, 8'h00, "R3");
    rd(3'd6, 8'h14, "R10");
    rd(3'd6, 8'h10, "R10");
    cts_i = 0; tick();
    rd(3'd6, 8'h01, "R10");
    // loopback
    ser_tx_i = 0;
    wr(3'd4, 8'h13);
    tick();
    rd(3'd6, 8'h33, "R11");
    rd(3'd6, 8'h30, "R11");
    chk("R11", {14'd0, sout, rx_ser_o}, 16'h0002);
    chk("R11", {12'd0, dtr_o, rts_o, out1_o, out2_o}, 16'h0000);
    dcd_i = 1; tick();
    rd(3'd6, 8'h30, "R11");
    wr(3'd4, 8'h00);
    tick();
    chk("R11", {15'd0, sout}, 16'd0);
    repeat (3) tick();
  endtask

  initial begin
    bit timed_out;
    timed_out = 0;
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule